// File: doc/BRIEF.md
# Gamma Breathing PWM Generator

This block drives one LED channel with an 8-bit duty value and a matching 256-step PWM bit. In waveform mode it produces a repeating "breathing" shape: after a one-off dark delay it brightens along a gamma-1.8 curve, stays at full, dims along the same curve backwards, then stays dark before the next brightening. Every segment length comes from a small logarithmic code. In direct mode the duty simply follows a programmed byte.

Time advances only on a timebase `tick` input. One time unit, the shortest non-zero segment, is `32*STEP_TICKS` ticks. A ramp always has 32 steps. Timing codes reach the engine only when `upd` is pulsed. That pulse, or a `mode_start` pulse, restarts the shape from the dark delay. The delay does not come back on later repetitions.

Top module: `breath_pwm_gen`

## Requirements
- R1: Out of reset the duty output is 0, the PWM bit is 0, and every loaded timing code is 0.
- R2: With `wave_mode` = 0 the duty output equals `duty_in` one clock after it is presented.
- R3: The PWM bit is high for exactly `duty` clocks out of any 256 consecutive clocks while `duty` is steady. It is never high while `duty` is 0.
- R4: A `upd` or `mode_start` pulse restarts the shape with the dark delay, during which duty is 0. For `delay_code` and `gap_code`, code 0 gives 0 ticks and code k (1..10) gives `32*STEP_TICKS*2^(k-1)` ticks.
- R5: The brightening ramp shows the 32 table values 0,1,3,5,8,12,16,21,26,32,38,45,52,60,68,76,85,95,105,115,125,136,148,160,172,185,198,211,225,239,254,255 in rising order. Each value lasts `STEP_TICKS*2^rise_code` ticks.
- R6: After the ramp the duty stays at 255 for a time set by `peak_code`. Code 0 gives 0 ticks and code k (1..8) gives `32*STEP_TICKS*2^(k-1)` ticks.
- R7: The dimming ramp walks the same table from index 31 down to 0. Each value lasts `STEP_TICKS*2^fall_code` ticks.
- R8: After dimming, duty is 0 for the `gap_code` time. The shape then repeats from the brightening ramp, with no delay segment.
- R9: Changes on the code inputs without a `upd` pulse leave the running shape unchanged. A later `mode_start` restart still uses the codes from the last `upd`.
- R10: A code above its largest listed value behaves as the largest listed value (10 for delay and gap, 8 for peak).
- R11: In waveform mode the duty output changes only in the clock after a `tick` or a restart pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase pulse, one clock wide |
| wave_mode | input | 1 | 1 selects waveform mode, 0 selects direct mode |
| mode_start | input | 1 | Pulse that restarts the shape, including the delay |
| upd | input | 1 | Loads the code inputs and restarts the shape |
| delay_code | input | 4 | Dark delay before the first ramp |
| rise_code | input | 3 | Brightening ramp step length |
| peak_code | input | 4 | Full-brightness time |
| fall_code | input | 3 | Dimming ramp step length |
| gap_code | input | 4 | Dark time between repetitions |
| duty_in | input | 8 | Duty used in direct mode |
| duty | output | 8 | Registered duty value |
| pwm_out | output | 1 | PWM bit, high while the free-running counter is below `duty` |

## Verification
A tick or restart moves the phase register on the same edge, and `duty` follows one edge later. Skipping a zero-length segment can add one more edge, but it never changes the duty value. The bench therefore drives each tick for one clock and then waits five clocks before it compares. It compares against a shape that it computes from the loaded codes and the number of ticks since the last restart. Direct-mode duty is due one clock after `duty_in` is applied. The PWM bit lags `duty` by one clock, so the bench counts it over 256 whole clocks after `duty` has settled.

// File: rtl/bpg_pkg.sv
package bpg_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_DELAY = 3'd1,
    PH_RISE  = 3'd2,
    PH_PEAK  = 3'd3,
    PH_FALL  = 3'd4,
    PH_GAP   = 3'd5
  } bpg_phase_e;

  typedef struct packed {
    logic [3:0] delay;
    logic [2:0] rise;
    logic [3:0] peak;
    logic [2:0] fall;
    logic [3:0] gap;
  } bpg_times_t;

  localparam int unsigned RAMP_STEPS = 32;
  localparam int unsigned IDX_W      = 5;
  localparam int unsigned DELAY_MAX  = 10;
  localparam int unsigned PEAK_MAX   = 8;

  // gamma 1.8 brightness curve, 32 points
  function automatic logic [7:0] gamma_lut(input logic [IDX_W-1:0] i);
    logic [7:0] v;
    case (i)
      5'd0:  v = 8'd0;    5'd1:  v = 8'd1;    5'd2:  v = 8'd3;    5'd3:  v = 8'd5;
      5'd4:  v = 8'd8;    5'd5:  v = 8'd12;   5'd6:  v = 8'd16;   5'd7:  v = 8'd21;
      5'd8:  v = 8'd26;   5'd9:  v = 8'd32;   5'd10: v = 8'd38;   5'd11: v = 8'd45;
      5'd12: v = 8'd52;   5'd13: v = 8'd60;   5'd14: v = 8'd68;   5'd15: v = 8'd76;
      5'd16: v = 8'd85;   5'd17: v = 8'd95;   5'd18: v = 8'd105;  5'd19: v = 8'd115;
      5'd20: v = 8'd125;  5'd21: v = 8'd136;  5'd22: v = 8'd148;  5'd23: v = 8'd160;
      5'd24: v = 8'd172;  5'd25: v = 8'd185;  5'd26: v = 8'd198;  5'd27: v = 8'd211;
      5'd28: v = 8'd225;  5'd29: v = 8'd239;  5'd30: v = 8'd254;  default: v = 8'd255;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/bpg_times.sv
module bpg_times
  import bpg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  bpg_times_t staged,
  output bpg_times_t active
);

  bpg_times_t active_q;
  bpg_times_t active_d;

  always_comb begin
    active_d = active_q;
    if (load) active_d = staged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= '0;
    else        active_q <= active_d;
  end

  assign active = active_q;

endmodule

// File: rtl/bpg_seq.sv
module bpg_seq
  import bpg_pkg::*;
#(
  parameter int unsigned STEP_TICKS = 1,
  parameter int unsigned CNT_W      = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 restart,
  input  bpg_times_t           times,
  output bpg_phase_e           phase,
  output logic [IDX_W-1:0]     idx
);

  localparam int unsigned UNIT = RAMP_STEPS * STEP_TICKS;

  function automatic logic [CNT_W-1:0] seg_len(input logic [3:0] c, input int unsigned cmax);
    int unsigned k;
    k = (int'(c) > cmax) ? cmax : int'(c);
    if (k == 0) return '0;
    return CNT_W'(UNIT << (k - 1));
  endfunction

  function automatic logic [CNT_W-1:0] step_len(input logic [2:0] c);
    return CNT_W'(STEP_TICKS << c);
  endfunction

  bpg_phase_e        ph_q, ph_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  logic [CNT_W-1:0]  len_delay, len_peak, len_gap, len_rise, len_fall;

  always_comb begin
    len_delay = seg_len(times.delay, DELAY_MAX);
    len_peak  = seg_len(times.peak, PEAK_MAX);
    len_gap   = seg_len(times.gap, DELAY_MAX);
    len_rise  = step_len(times.rise);
    len_fall  = step_len(times.fall);
  end

  always_comb begin
    ph_d  = ph_q;
    idx_d = idx_q;
    cnt_d = cnt_q;
    if (restart) begin
      ph_d  = PH_DELAY;
      idx_d = '0;
      cnt_d = '0;
    end else begin
      case (ph_q)
        PH_DELAY: begin
          if (len_delay == '0) begin
            ph_d = PH_RISE; idx_d = '0; cnt_d = '0;
          end else if (tick) begin
            if (cnt_q == len_delay - 1'b1) begin
              ph_d = PH_RISE; idx_d = '0; cnt_d = '0;
            end else cnt_d = cnt_q + 1'b1;
          end
        end
        PH_RISE: begin
          if (tick) begin
            if (cnt_q == len_rise - 1'b1) begin
              cnt_d = '0;
              if (idx_q == IDX_W'(RAMP_STEPS - 1)) ph_d = PH_PEAK;
              else idx_d = idx_q + 1'b1;
            end else cnt_d = cnt_q + 1'b1;
          end
        end
        PH_PEAK: begin
          if (len_peak == '0) begin
            ph_d = PH_FALL; idx_d = IDX_W'(RAMP_STEPS - 1); cnt_d = '0;
          end else if (tick) begin
            if (cnt_q == len_peak - 1'b1) begin
              ph_d = PH_FALL; idx_d = IDX_W'(RAMP_STEPS - 1); cnt_d = '0;
            end else cnt_d = cnt_q + 1'b1;
          end
        end
        PH_FALL: begin
          if (tick) begin
            if (cnt_q == len_fall - 1'b1) begin
              cnt_d = '0;
              if (idx_q == '0) ph_d = PH_GAP;
              else idx_d = idx_q - 1'b1;
            end else cnt_d = cnt_q + 1'b1;
          end
        end
        PH_GAP: begin
          if (len_gap == '0) begin
            ph_d = PH_RISE; idx_d = '0; cnt_d = '0;
          end else if (tick) begin
            if (cnt_q == len_gap - 1'b1) begin
              ph_d = PH_RISE; idx_d = '0; cnt_d = '0;
            end else cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          ph_d = PH_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      idx_q <= '0;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      idx_q <= idx_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase = ph_q;
  assign idx   = idx_q;

endmodule

// File: rtl/bpg_shape.sv
module bpg_shape
  import bpg_pkg::*;
(
  input  bpg_phase_e        phase,
  input  logic [IDX_W-1:0]  idx,
  output logic [7:0]        level
);

  always_comb begin
    case (phase)
      PH_RISE, PH_FALL: level = gamma_lut(idx);
      PH_PEAK:          level = 8'hFF;
      default:          level = 8'h00;
    endcase
  end

endmodule

// File: rtl/bpg_pwm.sv
module bpg_pwm #(
  parameter int unsigned DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] level,
  output logic              pwm
);

  logic [DUTY_W-1:0] ramp_q, ramp_d;
  logic              pwm_q, pwm_d;

  always_comb begin
    ramp_d = ramp_q + 1'b1;
    pwm_d  = (ramp_q < level);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramp_q <= '0;
      pwm_q  <= 1'b0;
    end else begin
      ramp_q <= ramp_d;
      pwm_q  <= pwm_d;
    end
  end

  assign pwm = pwm_q;

endmodule

// File: rtl/breath_pwm_gen.sv
module breath_pwm_gen
  import bpg_pkg::*;
#(
  parameter int unsigned STEP_TICKS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wave_mode,
  input  logic       mode_start,
  input  logic       upd,
  input  logic [3:0] delay_code,
  input  logic [2:0] rise_code,
  input  logic [3:0] peak_code,
  input  logic [2:0] fall_code,
  input  logic [3:0] gap_code,
  input  logic [7:0] duty_in,
  output logic [7:0] duty,
  output logic       pwm_out
);

  localparam int unsigned CNT_W = $clog2(RAMP_STEPS * STEP_TICKS * (1 << (DELAY_MAX - 1))) + 1;

  bpg_times_t       staged, active;
  bpg_phase_e       phase;
  logic [IDX_W-1:0] idx;
  logic [7:0]       wave_level;
  logic [7:0]       duty_q, duty_d;
  logic             restart;

  assign staged  = '{delay: delay_code, rise: rise_code, peak: peak_code,
                     fall: fall_code, gap: gap_code};
  assign restart = upd | mode_start;

  bpg_times u_times (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (upd),
    .staged (staged),
    .active (active)
  );

  bpg_seq #(.STEP_TICKS(STEP_TICKS), .CNT_W(CNT_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .restart (restart),
    .times   (active),
    .phase   (phase),
    .idx     (idx)
  );

  bpg_shape u_shape (
    .phase (phase),
    .idx   (idx),
    .level (wave_level)
  );

  always_comb begin
    duty_d = wave_mode ? wave_level : duty_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) duty_q <= '0;
    else        duty_q <= duty_d;
  end

  bpg_pwm #(.DUTY_W(8)) u_pwm (
    .clk   (clk),
    .rst_n (rst_n),
    .level (duty_q),
    .pwm   (pwm_out)
  );

  assign duty = duty_q;

endmodule

// File: rtl/bpg_checker.sv
module bpg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wave_mode,
  input logic       mode_start,
  input logic       upd,
  input logic [7:0] duty_in,
  input logic [7:0] duty,
  input logic       pwm_out
);

  p_direct_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wave_mode |=> (duty == $past(duty_in)));

  p_dark_after_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_mode && (upd || mode_start)) ##1 wave_mode |=> (duty == 8'd0));

  p_quiet_when_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == 8'd0) |=> !pwm_out);

  p_hold_between_ticks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_mode && !tick && !upd && !mode_start) ##1 wave_mode |=> $stable(duty));

endmodule

bind breath_pwm_gen bpg_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .wave_mode  (wave_mode),
  .mode_start (mode_start),
  .upd        (upd),
  .duty_in    (duty_in),
  .duty       (duty),
  .pwm_out    (pwm_out)
);

// File: tb/breath_pwm_gen_tb_top.sv
module breath_pwm_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, wave_mode = 1'b1, mode_start = 1'b0, upd = 1'b0;
  logic [3:0] delay_code = '0, peak_code = '0, gap_code = '0;
  logic [2:0] rise_code = '0, fall_code = '0;
  logic [7:0] duty_in = '0;
  logic [7:0] duty;
  logic       pwm_out;

  int n_chk = 0, n_bad = 0;
  int a_delay = 0, a_rise = 0, a_peak = 0, a_fall = 0, a_gap = 0;
  int elapsed = 0;
  int exp_q[$];
  string tag_q[$];
  event smp;

  always #2 clk = ~clk;

  breath_pwm_gen #(.STEP_TICKS(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wave_mode(wave_mode),
    .mode_start(mode_start), .upd(upd), .delay_code(delay_code),
    .rise_code(rise_code), .peak_code(peak_code), .fall_code(fall_code),
    .gap_code(gap_code), .duty_in(duty_in), .duty(duty), .pwm_out(pwm_out)
  );

  function automatic int curve(int i);
    int t[32] = '{0,1,3,5,8,12,16,21,26,32,38,45,52,60,68,76,
                  85,95,105,115,125,136,148,160,172,185,198,211,225,239,254,255};
    return t[i];
  endfunction

  function automatic int span(int c, int cmax);
    int k = (c > cmax) ? cmax : c;
    return (k == 0) ? 0 : (32 << (k - 1));
  endfunction

  function automatic int expect_at(int j);
    int l0 = span(a_delay, 10), s1 = 1 << a_rise, l2 = span(a_peak, 8);
    int s3 = 1 << a_fall, l4 = span(a_gap, 10);
    int p = 32*s1 + l2 + 32*s3 + l4;
    if (j < l0) return 0;
    j = (j - l0) % p;
    if (j < 32*s1) return curve(j / s1);
    j -= 32*s1;
    if (j < l2) return 255;
    j -= l2;
    if (j < 32*s3) return curve(31 - j / s3);
    return 0;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops the expected duty and compares
  always @(smp) begin
    if (exp_q.size() == 0) check("scoreboard-empty", 1, 0);
    else check(tag_q.pop_front(), int'(duty), exp_q.pop_front());
  end

  task automatic push_and_sample(string req);
    exp_q.push_back(expect_at(elapsed));
    tag_q.push_back(req);
    ->smp;
    #0;
  endtask

  task automatic load_codes(int d, int r, int p, int f, int g, string req);
    @(negedge clk);
    delay_code = 4'(d); rise_code = 3'(r); peak_code = 4'(p);
    fall_code = 3'(f); gap_code = 4'(g); upd = 1'b1;
    @(negedge clk); upd = 1'b0;
    a_delay = d; a_rise = r; a_peak = p; a_fall = f; a_gap = g; elapsed = 0;
    repeat (3) @(negedge clk);
    push_and_sample(req);
  endtask

  task automatic run_ticks(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      elapsed++;
      repeat (4) @(negedge clk);
      push_and_sample(req);
    end
  endtask

  task automatic count_pwm(int exp, string req);
    int hi = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
    check(req, hi, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 duty", int'(duty), 0);
    check("R1 pwm", int'(pwm_out), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 duty after release", int'(duty), 0);

    // direct mode
    wave_mode = 1'b0; duty_in = 8'hA5;
    @(negedge clk);
    check("R2 direct", int'(duty), 8'hA5);
    count_pwm(8'hA5, "R3 pwm A5");
    duty_in = 8'h00; @(negedge clk);
    check("R2 direct zero", int'(duty), 0);
    count_pwm(0, "R3 pwm zero");
    duty_in = 8'hFF; @(negedge clk);
    check("R2 direct full", int'(duty), 255);
    count_pwm(255, "R3 pwm full");
    wave_mode = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 codes zero, idle dark", int'(duty), 0);

    // full shape with a delay, then a repeat
    load_codes(1, 0, 1, 0, 1, "R4 restart");
    run_ticks(32, "R4 delay");
    run_ticks(32, "R5 rise");
    run_ticks(10, "R6 peak");
    repeat (50) @(negedge clk);
    check("R11 no tick no change", int'(duty), 255);
    run_ticks(22, "R6 peak");
    run_ticks(32, "R7 fall");
    run_ticks(32, "R8 gap");
    run_ticks(40, "R8 repeat no delay");

    // staged codes without update are ignored
    @(negedge clk);
    delay_code = 4'd0; rise_code = 3'd2; peak_code = 4'd0; fall_code = 3'd1; gap_code = 4'd0;
    run_ticks(40, "R9 staged ignored");

    // mode_start restarts with the loaded codes
    @(negedge clk); mode_start = 1'b1;
    @(negedge clk); mode_start = 1'b0;
    elapsed = 0;
    repeat (3) @(negedge clk);
    push_and_sample("R9 restart uses loaded");
    run_ticks(40, "R4 delay again");

    // longer steps, no delay, no peak
    load_codes(0, 1, 0, 2, 2, "R4 zero delay");
    run_ticks(64, "R5 rise step2");
    run_ticks(128, "R7 fall step4");
    run_ticks(70, "R8 gap 64");

    // peak code beyond range
    load_codes(0, 0, 12, 0, 0, "R10 restart");
    run_ticks(32 + 4096 + 40, "R10 peak saturates");

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule